// File: doc/BRIEF.md
# Accumulator Stored-Program Core

This block is a small multi-cycle processor. Code and data live together in one synchronous memory that sits outside the block, and every word in that memory is reached by its address. The core steps through fetch, decode and execute, one state per cycle. A program counter points at the next instruction. Each memory access first places an address in an address register. The word then moves through a data register. Results are kept in an accumulator.

The instruction set has four instructions: load, add, store and halt. Once it halts, the core makes no further memory accesses and holds its halted flag high. The accumulator is driven to a port so that the result of a run can be observed.

The memory port is a plain single-port interface with no handshake. The address and write data are always taken from the internal address and data registers. A read returns data one cycle after the address is presented, and the control sequence inserts the wait state that this latency needs.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and the halted flag. After reset is released, the first instruction fetch presents address 1 on `mem_addr` one cycle later.
- R2: An instruction word holds the opcode in bits 7:6 and a 6-bit operand address in bits 5:0. The opcodes are 00 = load, 01 = add, 10 = store and 11 = halt. For halt, the operand bits are ignored.
- R3: Instructions are fetched from consecutive addresses, and the program counter advances by one for each fetch.
- R4: Load copies the memory word at its operand address into the accumulator.
- R5: Add adds the memory word at its operand address to the accumulator, and the sum wraps modulo 256.
- R6: Store writes the accumulator to its operand address. `mem_we` is high for exactly one cycle per store, with `mem_wdata` equal to the accumulator value.
- R7: After halt, `halted` stays high, `mem_we` stays low and `mem_addr` no longer changes until the next reset.
- R8: Load and add each take 8 cycles and store takes 6 cycles. `halted` rises 5 cycles after the fetch of the halt instruction begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 6 | Memory address, taken from the address register |
| mem_wdata | output | 8 | Memory write data, taken from the data register |
| mem_we | output | 1 | Memory write enable, one cycle per store |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |
| acc_out | output | 8 | Current accumulator value |

## Verification
The hardest case to reach is a store followed closely by a load or add of the same address. That exercises write-then-read through the shared memory, and it only happens when operands collide. The random programs therefore draw every operand address from a narrow eight-word window, so that stores and reads overlap often. Each program ends with a halt, and the port is watched for a number of idle cycles after that.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_STORE = 2'b10,
    OP_END   = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    ST_FADDR, ST_FWAIT, ST_FLATCH, ST_DECODE,
    ST_OADDR, ST_OWAIT, ST_OLATCH, ST_EXEC,
    ST_STORE, ST_HALT
  } state_e;
endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  op,
  output logic pc_inc,
  output logic mar_from_pc,
  output logic mar_from_ir,
  output logic mdr_from_mem,
  output logic mdr_from_acc,
  output logic ir_load,
  output logic acc_load,
  output logic mem_we,
  output logic halted
);
  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FADDR;
      halted <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_OADDR && op == OP_END) halted <= 1'b1;
    end
  end

  always_comb begin
    nxt          = state;
    pc_inc       = 1'b0;
    mar_from_pc  = 1'b0;
    mar_from_ir  = 1'b0;
    mdr_from_mem = 1'b0;
    mdr_from_acc = 1'b0;
    ir_load      = 1'b0;
    acc_load     = 1'b0;
    mem_we       = 1'b0;
    unique case (state)
      ST_FADDR: begin
        mar_from_pc = 1'b1;
        pc_inc      = 1'b1;
        nxt         = ST_FWAIT;
      end
      ST_FWAIT:  nxt = ST_FLATCH;
      ST_FLATCH: begin
        mdr_from_mem = 1'b1;
        nxt          = ST_DECODE;
      end
      ST_DECODE: begin
        ir_load = 1'b1;
        nxt     = ST_OADDR;
      end
      ST_OADDR: begin
        if (op == OP_END) begin
          nxt = ST_HALT;
        end else begin
          mar_from_ir = 1'b1;
          if (op == OP_STORE) begin
            mdr_from_acc = 1'b1;
            nxt          = ST_STORE;
          end else begin
            nxt = ST_OWAIT;
          end
        end
      end
      ST_OWAIT:  nxt = ST_OLATCH;
      ST_OLATCH: begin
        mdr_from_mem = 1'b1;
        nxt          = ST_EXEC;
      end
      ST_EXEC: begin
        acc_load = 1'b1;
        nxt      = ST_FADDR;
      end
      ST_STORE: begin
        mem_we = 1'b1;
        nxt    = ST_FADDR;
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_FADDR;
    endcase
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] sum;

  assign sum    = acc + operand;
  assign result = (op == OP_ADD) ? sum : operand;
endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_inc,
  input  logic              mar_from_pc,
  input  logic              mar_from_ir,
  input  logic              mdr_from_mem,
  input  logic              mdr_from_acc,
  input  logic              ir_load,
  input  logic              acc_load,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_result,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc
);
  logic [ADDR_W-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= ADDR_W'(1);
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (pc_inc) pc <= pc + ADDR_W'(1);
      if (mar_from_pc)      mar <= pc;
      else if (mar_from_ir) mar <= ir[ADDR_W-1:0];
      if (mdr_from_mem)      mdr <= mem_rdata;
      else if (mdr_from_acc) mdr <= acc;
      if (ir_load)  ir  <= mdr;
      if (acc_load) acc <= alu_result;
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [DATA_W-1:0] acc_out
);
  logic pc_inc, mar_from_pc, mar_from_ir, mdr_from_mem, mdr_from_acc;
  logic ir_load, acc_load;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr, ir, acc, alu_result;
  op_e op;

  assign op = op_e'(ir[DATA_W-1 -: 2]);

  acc_cpu_ctrl u_ctrl (
    .clk, .rst, .op,
    .pc_inc, .mar_from_pc, .mar_from_ir, .mdr_from_mem, .mdr_from_acc,
    .ir_load, .acc_load, .mem_we, .halted
  );

  acc_cpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst,
    .pc_inc, .mar_from_pc, .mar_from_ir, .mdr_from_mem, .mdr_from_acc,
    .ir_load, .acc_load, .mem_rdata, .alu_result,
    .mar, .mdr, .ir, .acc
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op, .acc, .operand(mdr), .result(alu_result)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign acc_out   = acc;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              halted,
  input logic [DATA_W-1:0] acc_out,
  input logic              in_exec
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_out == '0 && !halted && !mem_we));

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r7_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr));

  a_r6_we_single: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r6_wdata_acc: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == acc_out));

  a_r4_acc_only_exec: assert property (@(posedge clk) disable iff (rst)
    !in_exec |=> $stable(acc_out));
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_we(mem_we), .halted(halted), .acc_out(acc_out), .in_exec(acc_load)
);

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_we;
  logic [7:0] mem_rdata;
  logic       halted;
  logic [7:0] acc_out;

  logic [7:0] mem  [64];
  logic [7:0] rmem [64];
  int checks = 0, fails = 0, gcyc = 0;
  int exp_cycles, exp_stores;
  logic [7:0] exp_acc;

  always #4 clk = ~clk;

  acc_cpu i_acc_cpu (.clk, .rst, .mem_addr, .mem_wdata, .mem_we, .mem_rdata, .halted, .acc_out);

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected <= 150000", gcyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input int op, input int a);
    return 8'((op << 6) | (a & 63));
  endfunction

  // reference: runs the program in rmem
  task automatic ref_run();
    int pc = 1;
    exp_acc = 0; exp_cycles = 0; exp_stores = 0;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] w = rmem[pc];
      int a = w & 63;
      pc = (pc + 1) & 63;
      case (w >> 6)
        0: begin exp_acc = rmem[a]; exp_cycles += 8; end
        1: begin exp_acc = exp_acc + rmem[a]; exp_cycles += 8; end
        2: begin rmem[a] = exp_acc; exp_cycles += 6; exp_stores++; end
        default: begin exp_cycles += 5; break; end
      endcase
    end
  endtask

  task automatic run_prog(input string tag);
    int c = 0, st = 0, bad = -1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 64; i++) rmem[i] = mem[i];
    ref_run();
    check("R1 reset acc", int'(acc_out), 0);
    check("R1 reset halted", int'(halted), 0);
    rst = 1'b0;
    while (c < 2000) begin
      @(posedge clk); c++;
      @(negedge clk);
      if (c == 1) check("R1 first fetch address", int'(mem_addr), 1);
      if (mem_we) st++;
      if (halted) break;
    end
    check({"R8 R3 cycles to halt ", tag}, c, exp_cycles);
    check({"R4 R5 final acc ", tag}, int'(acc_out), int'(exp_acc));
    check({"R6 store count ", tag}, st, exp_stores);
    for (int i = 0; i < 64; i++) if (mem[i] !== rmem[i] && bad < 0) bad = i;
    check({"R6 memory image mismatch index ", tag}, bad, -1);
    begin
      logic [5:0] a0 = mem_addr;
      int w = 0, h = 0, mv = 0;
      repeat (12) begin
        @(negedge clk);
        if (mem_we) w++;
        if (!halted) h++;
        if (mem_addr != a0) mv++;
      end
      check({"R7 writes after halt ", tag}, w, 0);
      check({"R7 halted dropped ", tag}, h, 0);
      check({"R7 address moved ", tag}, mv, 0);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  endtask

  initial begin
    void'($urandom(32'd4242));
    // directed: worked example, 12 + 23 stored at 6
    clear_mem();
    mem[1] = mk(0, 5); mem[2] = mk(1, 6); mem[3] = mk(2, 6); mem[4] = mk(3, 0);
    mem[5] = 8'd12; mem[6] = 8'd23;
    run_prog("example");
    check("R6 example sum at address 6", int'(mem[6]), 35);
    // directed: add wraps modulo 256
    clear_mem();
    mem[1] = mk(0, 40); mem[2] = mk(1, 41); mem[3] = mk(3, 0);
    mem[40] = 8'd200; mem[41] = 8'd100;
    run_prog("wrap");
    check("R5 wrap result", int'(acc_out), 44);
    // directed: halt with operand bits set, and halt as the first instruction
    clear_mem();
    mem[1] = 8'hFF;
    run_prog("halt_ff");
    check("R2 halt ignores operand", int'(halted), 1);
    // directed: load only, then store twice to one address
    clear_mem();
    mem[1] = mk(0, 50); mem[2] = mk(2, 51); mem[3] = mk(2, 51); mem[4] = mk(3, 9);
    mem[50] = 8'hA5;
    run_prog("load_store");
    check("R4 load value", int'(acc_out), 8'hA5);
    // random programs over a narrow data window
    for (int p = 0; p < 25; p++) begin
      int n = 1 + int'($urandom % 12);
      clear_mem();
      for (int i = 32; i < 64; i++) mem[i] = 8'($urandom);
      for (int i = 1; i <= n; i++) mem[i] = mk(int'($urandom % 3), 32 + int'($urandom % 8));
      mem[n + 1] = mk(3, int'($urandom % 64));
      run_prog($sformatf("rand%0d", p));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule